// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the software-facing control layer of a memory-mapped hashing peripheral. A 32-bit register bus writes message words into a 64-byte input window. The block packs them into 512-bit blocks and hands each full block, together with the current 256-bit chaining value, to an external compression unit over a request/acknowledge handshake. It keeps the running byte count. When software issues the final-round command, it builds the standard message padding. It also presents the chaining value or the finished digest in either byte order.

The compression rounds sit outside this block, behind the `cmp_*` port group. While a block is waiting for compression, `in_stall` tells the bus side to hold off new data. The chaining value can be read and rewritten at any time the block is not stalled, so software can save a partial hash and restore it later. The enable bits for the input and output DMA are stored and read back but drive nothing.

Top module: `hash_regfront`

## Requirements
- R1: After reset, the control register (offset 0x00) and the byte-count register (offset 0x04) read 0, and `cmp_req` and `in_stall` are low.
- R2: A control write with bit 0 set loads the initial vector of the algorithm in bits 5:4 (0 = SHA-256, 1 = SHA-224, 2 or 3 = SHA-1; SHA-1 leaves state words 5 to 7 zero). The same write clears the byte counter and the input buffer, and control bit 0 then reads 1 until the digest is ready.
- R3: A write anywhere in offsets 0x80 to 0xBF stores into the next free buffer word, whatever its offset. On the sixteenth word, `cmp_req` and `in_stall` rise. `cmp_block` carries word 0 in bits 511:480 and word 15 in bits 31:0, and `cmp_state` carries the chaining value.
- R4: `cmp_req`, `cmp_block` and `cmp_state` hold until `cmp_ack`. On the acknowledge, `cmp_next` becomes the chaining value, the buffer empties and the stall clears. A start write aborts a pending request.
- R5: Control bit 1 while filling starts the final round. With 13 or fewer words buffered, a single block is sent: the data, the word 0x80000000, zeros, then the 64-bit message bit length, high word in word 14 and low word in word 15.
- R6: With 14 or 15 words buffered, the final round sends two blocks. The first holds the data, 0x80000000 and zeros. The second holds zeros and the bit length in words 14 and 15.
- R7: The byte-count register changes only when the final round completes, and then shows the total number of bytes written since start.
- R8: Control bit 1 reads 1 from the final-round command until the last padded block is acknowledged. After that, bits 0 and 1 both read 0.
- R9: Offsets 0x40+4k (k = 0..7) read chaining word k, where word 0 is `cmp_state[255:224]`. With control bit 3 at 1 the word reads as stored. With bit 3 at 0 its bytes are reversed.
- R10: A write to offset 0x40+4k while `in_stall` is low replaces chaining word k, using the same byte order as a read. The new value is used by the next compression request.
- R11: After the final round, SHA-224 reads word 7 as zero, and SHA-1 reads words 5 to 7 as zero.
- R12: Control bits 2, 3, 5:4, 9 and 10 read back as written, and bit 8 reads 0. A control write with bit 8 set while filling empties the buffer and clears the byte counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| in_stall | output | 1 | Back-pressure: window and hash writes are not accepted |
| cmp_req | output | 1 | Compression request |
| cmp_alg | output | 2 | Algorithm selection for the compression unit |
| cmp_block | output | 512 | Message block to compress |
| cmp_state | output | 256 | Chaining value input to compression |
| cmp_ack | input | 1 | Compression done, `cmp_next` valid |
| cmp_next | input | 256 | New chaining value |

## Verification
The hardest case to reach is the two-block final round. It needs exactly 14 or 15 words sitting in the buffer when the final command arrives, and that only happens after earlier full blocks have been acknowledged through the stall. The stimulus writes chosen word counts across block boundaries, with varied window offsets. A stub compression unit in the bench answers each request after a delay, and a scoreboard compares every padded block and chaining value against a model built from the requirements. Save/restore is reached by overwriting a chaining word between blocks. The digest must then reflect it.

// File: rtl/hrf_pkg.sv
// Shared constants, types and helper functions for the hash register front-end.
// Assumes 32-bit bus words, 16-word message blocks and a 256-bit chaining value.
package hrf_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int ST_WORDS  = 8;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int ST_W      = WORD_W * ST_WORDS;
    localparam int FILL_W    = $clog2(BLK_WORDS + 1);

    typedef enum logic [1:0] {PAD_NONE, PAD_ONE, PAD_FIRST, PAD_SECOND} pad_e;
    typedef enum logic [2:0] {S_IDLE, S_FILL, S_CMP, S_FIN1, S_FIN2} seq_e;

    // Initial chaining value for the given algorithm code.
    function automatic logic [ST_W-1:0] init_vec(input logic [1:0] alg);
        case (alg)
            2'd0:    return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                             32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
            2'd1:    return {32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                             32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
            default: return {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                             32'hc3d2e1f0, 96'h0};
        endcase
    endfunction

    // Reverse the byte order of one word.
    function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/hrf_inbuf.sv
// Input word collector: appends each pushed word at the next free slot.
// Assumes the caller never pushes when full; clr has priority over push.
module hrf_inbuf #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    localparam int FILL_W = $clog2(WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic [WORD_W-1:0]       din,
    output logic [WORDS*WORD_W-1:0] words,
    output logic [FILL_W-1:0]       fill
);
    // Fill pointer: reset, clear or advance on each push.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) fill <= '0;
        else if (push)     fill <= fill + 1'b1;
    end

    for (genvar i = 0; i < WORDS; i++) begin : g_slot
        logic [WORD_W-1:0] slot;
        // Slot storage: capture the word when this slot is next free.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    slot <= '0;
            else if (push && !clr && fill == FILL_W'(i))   slot <= din;
        end
        assign words[WORD_W*(WORDS-i)-1 -: WORD_W] = slot;
    end
endmodule

// File: rtl/hrf_pad.sv
// Block former: passes the buffer through or builds a padded final block.
// Assumes fill < WORDS; PAD_ONE is only chosen when fill <= WORDS-3.
module hrf_pad
    import hrf_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    localparam int FILL_W = $clog2(WORDS + 1)
) (
    input  logic [WORDS*WORD_W-1:0] words,
    input  logic [FILL_W-1:0]       fill,
    input  logic [2*WORD_W-1:0]     bitlen,
    input  pad_e                    mode,
    output logic [WORDS*WORD_W-1:0] block
);
    localparam logic [WORD_W-1:0] MARK = {1'b1, {(WORD_W-1){1'b0}}};

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WORD_W-1:0] dw, ow;
        assign dw = words[WORD_W*(WORDS-i)-1 -: WORD_W];
        // Select the word for slot i according to the padding mode.
        always_comb begin
            ow = '0;
            unique case (mode)
                PAD_NONE: ow = dw;
                PAD_ONE, PAD_FIRST: begin
                    if (i < int'(fill))                      ow = dw;
                    else if (i == int'(fill))                ow = MARK;
                    else if (mode == PAD_ONE && i == WORDS-2) ow = bitlen[2*WORD_W-1:WORD_W];
                    else if (mode == PAD_ONE && i == WORDS-1) ow = bitlen[WORD_W-1:0];
                end
                PAD_SECOND: begin
                    if (i == WORDS-2)      ow = bitlen[2*WORD_W-1:WORD_W];
                    else if (i == WORDS-1) ow = bitlen[WORD_W-1:0];
                end
            endcase
        end
        assign block[WORD_W*(WORDS-i)-1 -: WORD_W] = ow;
    end
endmodule

// File: rtl/hash_regfront.sv
// Register front-end of a hash peripheral: control/status, byte count,
// chaining value access, input window and compression handshake.
// Assumes one bus access per cycle and a compression unit that pulses cmp_ack once per request.
module hash_regfront
    import hrf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              in_stall,
    output logic              cmp_req,
    output logic [1:0]        cmp_alg,
    output logic [BLK_W-1:0]  cmp_block,
    output logic [ST_W-1:0]   cmp_state,
    input  logic              cmp_ack,
    input  logic [ST_W-1:0]   cmp_next
);
    seq_e              seq;
    logic [ST_W-1:0]   chain;
    logic [31:0]       bytes, bytes_vis;
    logic [1:0]        alg;
    logic              big_end, dma_in, dma_out, fifo_en, digest_ok;
    logic [BLK_W-1:0]  words;
    logic [FILL_W-1:0] fill;
    pad_e              mode;
    logic              wr_ctrl, wr_hash, wr_win, start, fin_req, fifo_clr, push;
    logic              one_blk, fin_done, buf_clr;
    logic [2:0]        hidx;
    logic [31:0]       hword, hmask;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:11], bus_wdata[7:6]};

    // Bus decode and command strobes.
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_W'(0);
    assign wr_hash  = bus_wr && bus_addr[7:5] == 3'b010;
    assign wr_win   = bus_wr && bus_addr[7:6] == 2'b10;
    assign start    = wr_ctrl && bus_wdata[0];
    assign fin_req  = wr_ctrl && !bus_wdata[0] && bus_wdata[1] && seq == S_FILL;
    assign fifo_clr = wr_ctrl && !bus_wdata[0] && bus_wdata[8] && seq == S_FILL;
    assign push     = wr_win && seq == S_FILL;
    assign hidx     = bus_addr[4:2];

    assign one_blk  = fill <= FILL_W'(BLK_WORDS - 3);
    assign fin_done = cmp_ack && !start && ((seq == S_FIN1 && one_blk) || seq == S_FIN2);
    assign buf_clr  = start || fifo_clr || fin_done || (cmp_ack && seq == S_CMP);

    assign in_stall  = seq inside {S_CMP, S_FIN1, S_FIN2};
    assign cmp_req   = in_stall;
    assign cmp_alg   = alg;
    assign cmp_state = chain;

    // Padding mode follows the sequencer state.
    always_comb begin
        unique case (seq)
            S_FIN1:  mode = one_blk ? PAD_ONE : PAD_FIRST;
            S_FIN2:  mode = PAD_SECOND;
            default: mode = PAD_NONE;
        endcase
    end

    hrf_inbuf #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_inbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(push),
        .din(bus_wdata), .words(words), .fill(fill)
    );

    hrf_pad #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_pad (
        .words(words), .fill(fill), .bitlen({29'd0, bytes, 3'd0}),
        .mode(mode), .block(cmp_block)
    );

    // Sequencer: filling, block compression and final-round padding.
    always_ff @(posedge clk) begin
        if (!rst_n) seq <= S_IDLE;
        else if (start) seq <= S_FILL;
        else begin
            unique case (seq)
                S_FILL: if (fin_req) seq <= S_FIN1;
                        else if (push && fill == FILL_W'(BLK_WORDS - 1)) seq <= S_CMP;
                S_CMP:  if (cmp_ack) seq <= S_FILL;
                S_FIN1: if (cmp_ack) seq <= one_blk ? S_IDLE : S_FIN2;
                S_FIN2: if (cmp_ack) seq <= S_IDLE;
                default: ;
            endcase
        end
    end

    // Configuration bits captured on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alg <= '0; big_end <= 1'b0; dma_in <= 1'b0; dma_out <= 1'b0; fifo_en <= 1'b0;
        end else if (wr_ctrl) begin
            alg <= bus_wdata[5:4]; big_end <= bus_wdata[3]; dma_in <= bus_wdata[2];
            dma_out <= bus_wdata[10]; fifo_en <= bus_wdata[9];
        end
    end

    // Running byte count, and its visible copy committed at the end of the final round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes <= '0; bytes_vis <= '0; digest_ok <= 1'b0;
        end else begin
            if (start || fifo_clr) bytes <= '0;
            else if (push)         bytes <= bytes + 32'd4;
            if (fin_done) bytes_vis <= bytes;
            if (start)         digest_ok <= 1'b0;
            else if (fin_done) digest_ok <= 1'b1;
        end
    end

    // Chaining value: initial vector, compression result or software overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else if (start) chain <= init_vec(bus_wdata[5:4]);
        else if (cmp_req && cmp_ack) chain <= cmp_next;
        else if (wr_hash && !in_stall)
            chain[(7 - hidx) * 32 +: 32] <= big_end ? bus_wdata : bswap(bus_wdata);
    end

    // Digest word view with truncation for the shorter algorithms.
    always_comb begin
        hword = chain[(7 - hidx) * 32 +: 32];
        hmask = '1;
        if (digest_ok && ((alg == 2'd1 && hidx == 3'd7) || (alg[1] && hidx >= 3'd5)))
            hmask = '0;
        hword = hword & hmask;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0))
            bus_rdata = {21'd0, dma_out, fifo_en, 3'd0, alg, big_end, dma_in,
                         seq inside {S_FIN1, S_FIN2}, seq != S_IDLE};
        else if (bus_addr == ADDR_W'(4)) bus_rdata = bytes_vis;
        else if (bus_addr[7:5] == 3'b010) bus_rdata = big_end ? hword : bswap(hword);
    end
endmodule

// File: rtl/hrf_checker.sv
// Protocol and state-loading checks for hash_regfront, attached by bind.
// Assumes ports only; start is decoded here from the bus independently.
module hrf_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [7:0]   bus_addr,
    input logic [31:0]  bus_wdata,
    input logic         cmp_req,
    input logic         cmp_ack,
    input logic [511:0] cmp_block,
    input logic [255:0] cmp_state,
    input logic [255:0] cmp_next
);
    logic start_w;
    assign start_w = bus_wr && bus_addr == 8'h00 && bus_wdata[0];

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req && !cmp_ack && !start_w |=> cmp_req);

    a_r4_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req && !cmp_ack && !start_w |=> $stable(cmp_block) && $stable(cmp_state));

    a_r4_ack_applies: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req && cmp_ack && !start_w |=> cmp_state == $past(cmp_next));

    a_r2_iv_sha256: assert property (@(posedge clk) disable iff (!rst_n)
        start_w && bus_wdata[5:4] == 2'd0 |=> cmp_state[255:224] == 32'h6a09e667);

    a_r2_iv_sha1: assert property (@(posedge clk) disable iff (!rst_n)
        start_w && bus_wdata[5] |=> cmp_state[255:224] == 32'h67452301 && cmp_state[95:0] == 96'h0);
endmodule

bind hash_regfront hrf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cmp_req(cmp_req), .cmp_ack(cmp_ack),
    .cmp_block(cmp_block), .cmp_state(cmp_state), .cmp_next(cmp_next)
);

// File: tb/hash_regfront_test.sv
// Scoreboard bench: the driver predicts every compression request, a monitor
// process pops and compares each one and answers with a stub compression result.
module hash_regfront_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         in_stall, cmp_req, cmp_ack = 1'b0;
    logic [1:0]   cmp_alg;
    logic [511:0] cmp_block;
    logic [255:0] cmp_state, cmp_next = '0;

    typedef struct {logic [511:0] blk; logic [255:0] st; string tag;} item_t;
    item_t exp_q[$];

    int nchk = 0, nerr = 0;
    bit finished = 0;
    logic [255:0] mstate;
    logic [31:0]  cur[16];
    int nw = 0, total = 0;
    logic [31:0] cfg = 32'h8;

    always #2.5 clk = ~clk;

    hash_regfront uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_stall(in_stall),
        .cmp_req(cmp_req), .cmp_alg(cmp_alg), .cmp_block(cmp_block),
        .cmp_state(cmp_state), .cmp_ack(cmp_ack), .cmp_next(cmp_next)
    );

    function automatic logic [255:0] stub(logic [255:0] s, logic [511:0] b);
        return {s[254:0], s[255]} ^ b[511:256] ^ b[255:0];
    endfunction

    function automatic logic [31:0] mword(int k);
        return mstate[(7-k)*32 +: 32];
    endfunction

    task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        while (in_stall) @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_block(logic [31:0] w[16], string tag);
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511-32*i -: 32] = w[i];
        exp_q.push_back('{blk: b, st: mstate, tag: tag});
        mstate = stub(mstate, b);
    endtask

    task automatic push_word(logic [31:0] v, logic [7:0] off);
        cur[nw] = v; nw++; total += 4;
        if (nw == 16) begin expect_block(cur, "R3 full block"); nw = 0; end
        bwrite(8'h80 + (off & 8'h3C), v);
    endtask

    task automatic start_hash(logic [1:0] alg, logic [255:0] iv);
        cfg = 32'h8 | (32'(alg) << 4);
        mstate = iv; nw = 0; total = 0;
        bwrite(8'h00, cfg | 32'h1);
    endtask

    task automatic do_final(string tag);
        logic [31:0] w[16];
        logic [63:0] len;
        logic [31:0] r;
        int guard = 0;
        len = 64'(total) * 8;
        for (int i = 0; i < 16; i++) w[i] = (i < nw) ? cur[i] : (i == nw) ? 32'h80000000 : 32'h0;
        if (nw <= 13) begin
            w[14] = len[63:32]; w[15] = len[31:0];
            expect_block(w, {tag, " single pad"});
        end else begin
            expect_block(w, {tag, " first pad"});
            for (int i = 0; i < 16; i++) w[i] = 32'h0;
            w[14] = len[63:32]; w[15] = len[31:0];
            expect_block(w, {tag, " second pad"});
        end
        bwrite(8'h00, cfg | 32'h2);
        bread(8'h00, r);
        chk("R8 final busy bit", 512'(r[1]), 512'(1));
        while (r[1] && guard < 200) begin bread(8'h00, r); guard++; end
        chk("R8 status after final", 512'(r), 512'(cfg));
        chk({tag, " queue drained"}, 512'(exp_q.size()), 512'(0));
    endtask

    // Monitor: compare each request with the scoreboard and acknowledge it.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmp_req) begin
                if (exp_q.size() == 0) begin
                    nchk++; nerr++;
                    $display("FAIL R4: unexpected request, actual 1 expected 0");
                    repeat (2) @(negedge clk);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk({it.tag, " block"}, cmp_block, it.blk);
                    chk({it.tag, " state R4"}, 512'(cmp_state), 512'(it.st));
                    repeat (2) @(negedge clk);
                end
                cmp_next = stub(cmp_state, cmp_block);
                cmp_ack = 1'b1;
                @(negedge clk);
                cmp_ack = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bread(8'h00, r); chk("R1 control", 512'(r), 512'(0));
        bread(8'h04, r); chk("R1 count", 512'(r), 512'(0));
        chk("R1 req/stall", 512'({cmp_req, in_stall}), 512'(0));

        // R2 SHA-256 start
        start_hash(2'd0, hrf_pkg::init_vec(2'd0));
        bread(8'h00, r); chk("R2 busy", 512'(r), 512'(32'h9));
        bread(8'h40, r); chk("R2 iv word0", 512'(r), 512'(32'h6a09e667));
        bread(8'h5C, r); chk("R9 word7 order", 512'(r), 512'(32'h5be0cd19));
        bwrite(8'h00, 32'h0);
        bread(8'h40, r); chk("R9 little endian", 512'(r), 512'(32'h67e6096a));
        bwrite(8'h00, cfg);

        // R3/R4 one full block plus four words, scattered offsets
        for (int i = 0; i < 20; i++) push_word(32'hA5000000 ^ (i * 32'h00010203), 8'((i * 20) % 64));
        bread(8'h04, r); chk("R7 count not yet committed", 512'(r), 512'(0));
        for (int k = 0; k < 8; k++) begin
            bread(8'h40 + 8'(4*k), r); chk("R4 chaining after ack", 512'(r), 512'(mword(k)));
        end
        // R10 save/restore overwrite
        bwrite(8'h48, 32'hDEADBEEF);
        mstate[5*32 +: 32] = 32'hDEADBEEF;
        bread(8'h48, r); chk("R10 overwrite readback", 512'(r), 512'(32'hDEADBEEF));
        do_final("R5");
        bread(8'h04, r); chk("R7 count committed", 512'(r), 512'(80));
        for (int k = 0; k < 8; k++) begin
            bread(8'h40 + 8'(4*k), r); chk("R9 digest", 512'(r), 512'(mword(k)));
        end

        // R6 SHA-224 with 14 words -> two pad blocks, R11 truncation
        start_hash(2'd1, hrf_pkg::init_vec(2'd1));
        bread(8'h40, r); chk("R2 sha224 iv", 512'(r), 512'(32'hc1059ed8));
        for (int i = 0; i < 14; i++) push_word(32'h13572468 + 32'(i), 8'(4*i));
        do_final("R6 sha224");
        bread(8'h58, r); chk("R11 sha224 word6", 512'(r), 512'(mword(6)));
        bread(8'h5C, r); chk("R11 sha224 word7 zero", 512'(r), 512'(0));
        bread(8'h04, r); chk("R7 count sha224", 512'(r), 512'(56));

        // R12 FIFO clear, then SHA-1 with 15 words
        start_hash(2'd2, hrf_pkg::init_vec(2'd2));
        for (int i = 0; i < 3; i++) push_word(32'hFFFF0000 | 32'(i), 8'h00);
        bwrite(8'h00, cfg | 32'h100);
        nw = 0; total = 0;
        for (int i = 0; i < 15; i++) push_word(32'h0BADF00D ^ 32'(i << 8), 8'h3C);
        do_final("R6 sha1");
        bread(8'h50, r); chk("R11 sha1 word4", 512'(r), 512'(mword(4)));
        for (int k = 5; k < 8; k++) begin
            bread(8'h40 + 8'(4*k), r); chk("R11 sha1 tail zero", 512'(r), 512'(0));
        end
        bread(8'h04, r); chk("R12 count after clear", 512'(r), 512'(60));
        bwrite(8'h00, 32'h72C);
        bread(8'h00, r); chk("R12 config readback", 512'(r), 512'(32'h62C));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule